// File: doc/BRIEF.md
# Branch Target Buffer with Per-Branch History Prediction

This block sits beside an instruction fetch stage. Each cycle the fetch stage presents its current fetch address and the block answers in the same cycle: whether the address holds a known branch, whether that branch is predicted taken, and the address fetch should use next. A known branch is predicted from its own record of recent outcomes. Each stored entry keeps a short shift register of the branch's last outcomes, and that history picks one of sixteen two-bit saturating counters belonging to the same entry. The counter's upper bit gives the direction.

The execution side reports resolved branches with the direction and target that actually occurred, plus the prediction that fetch acted on. Because lookups run ahead of resolution, that prediction travels with the branch and is returned here rather than recomputed. The block trains the entry's counter and history, allocates a new entry when an unknown branch turns out taken, and chooses the way to overwrite with a tree pseudo-LRU per set. When the prediction was wrong it issues a one-cycle redirect carrying the correct next address.

Top module: `btb_two_level`

## Requirements
- R1: After synchronous active-low reset every lookup misses and `redirect_valid` is low.
- R2: A lookup miss gives `pred_taken` = 0 and `pred_next` = `fetch_pc` + 4.
- R3: A resolution that misses and is not taken allocates nothing; a resolution that is taken and misses allocates an entry.
- R4: A freshly allocated entry starts with history 0 and all sixteen counters at 2, then is trained by its resolution; so the next lookup hits and predicts taken to the resolved target.
- R5: Counters are two-bit saturating (no wrap at 0 or 3); a counter value of 2 or 3 predicts taken.
- R6: On each resolution of a stored branch, the counter indexed by the entry's current 4-bit history moves one step toward the outcome, and the history shifts left with the outcome (1 = taken) entering bit 0.
- R7: A taken resolution stores the resolved target; a not-taken resolution leaves the stored target unchanged.
- R8: The 512 entries form 128 sets of 4 ways; set index is `pc[8:2]`, tag is `pc[31:9]`; at most one way matches. Allocation takes the lowest-numbered invalid way, else the tree pseudo-LRU victim; only resolutions that write an entry update the tree.
- R9: One cycle after a resolution whose predicted direction differs from the outcome, or whose predicted next address differs from the real next address (target if taken, `res_pc` + 4 if not), `redirect_valid` pulses high with `redirect_pc` equal to the real next address; otherwise it stays low.
- R10: When a lookup and a resolution address the same set in the same cycle, the lookup answer reflects the entry state after that resolution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | 32 | Fetch address to look up |
| pred_hit | output | 1 | Lookup found a stored branch |
| pred_taken | output | 1 | Predicted taken |
| pred_next | output | 32 | Predicted next fetch address |
| res_valid | input | 1 | A resolved branch is presented |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Actual direction |
| res_target | input | 32 | Actual taken target |
| res_pred_taken | input | 1 | Direction fetch had predicted |
| res_pred_next | input | 32 | Next address fetch had predicted |
| redirect_valid | output | 1 | One-cycle restart request |
| redirect_pc | output | 32 | Correct address to restart at |

## Verification
A lookup and a training update can land on the same set in one cycle, so the lookup must see the entry as the update leaves it. The bench provokes this by presenting the resolved address on `fetch_pc` in the resolution cycle: once for an allocation, where only a forwarded view can hit, and once for a hit whose target and history change, where the old and new state give different next addresses. The lookup answer in that cycle is compared with the post-update prediction worked out by hand, while the redirect from the same resolution is checked one cycle later.

// File: rtl/btb_pkg.sv
// Shared helpers for the branch target buffer.
// Assumes a four-way set so the replacement tree is three bits wide.
package btb_pkg;

    localparam int WAYS = 4;

    // Move a two-bit counter one step toward the outcome, saturating.
    function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic up);
        if (up) return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    // Way named by the tree: bit0 picks the half, bit1/bit2 pick inside it.
    function automatic logic [1:0] plru_victim(input logic [2:0] t);
        return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
    endfunction

    // Point every tree bit on the path away from the way just used.
    function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
        logic [2:0] n;
        n    = t;
        n[0] = ~w[1];
        if (!w[1]) n[1] = ~w[0];
        else       n[2] = ~w[0];
        return n;
    endfunction

endpackage

// File: rtl/btb_way_store.sv
// One way of the buffer: valid, tag, history, target and the packed
// pattern counters for every set. Two combinational read ports (lookup
// and update) and one write port. Only the valid bits are reset.
module btb_way_store #(
    parameter int SETS    = 128,
    parameter int IDX_W   = 7,
    parameter int TAG_W   = 23,
    parameter int HIST_W  = 4,
    parameter int ADDR_W  = 32,
    parameter int CTR_VEC = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   lk_idx,
    output logic               lk_valid,
    output logic [TAG_W-1:0]   lk_tag,
    output logic [HIST_W-1:0]  lk_hist,
    output logic [ADDR_W-1:0]  lk_target,
    output logic [CTR_VEC-1:0] lk_ctrs,
    input  logic [IDX_W-1:0]   up_idx,
    output logic               up_valid,
    output logic [TAG_W-1:0]   up_tag,
    output logic [HIST_W-1:0]  up_hist,
    output logic [CTR_VEC-1:0] up_ctrs,
    input  logic               we,
    input  logic               we_tgt,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic [HIST_W-1:0]  wr_hist,
    input  logic [ADDR_W-1:0]  wr_target,
    input  logic [CTR_VEC-1:0] wr_ctrs
);

    logic [SETS-1:0]    valid_q;
    logic [TAG_W-1:0]   tag_q  [SETS];
    logic [HIST_W-1:0]  hist_q [SETS];
    logic [ADDR_W-1:0]  tgt_q  [SETS];
    logic [CTR_VEC-1:0] ctr_q  [SETS];

    // Valid bits: cleared by reset, set on any write.
    always_ff @(posedge clk) begin
        if (!rst_n)  valid_q         <= '0;
        else if (we) valid_q[up_idx] <= 1'b1;
    end

    // Entry payload written by the training path.
    always_ff @(posedge clk) begin
        if (we) begin
            tag_q[up_idx]  <= wr_tag;
            hist_q[up_idx] <= wr_hist;
            ctr_q[up_idx]  <= wr_ctrs;
        end
        if (we_tgt) tgt_q[up_idx] <= wr_target;
    end

    // Read ports for lookup and training.
    always_comb begin
        lk_valid  = valid_q[lk_idx];
        lk_tag    = tag_q[lk_idx];
        lk_hist   = hist_q[lk_idx];
        lk_target = tgt_q[lk_idx];
        lk_ctrs   = ctr_q[lk_idx];
        up_valid  = valid_q[up_idx];
        up_tag    = tag_q[up_idx];
        up_hist   = hist_q[up_idx];
        up_ctrs   = ctr_q[up_idx];
    end

endmodule

// File: rtl/btb_plru.sv
// Tree pseudo-LRU state, three bits per set, for a four-way buffer.
// Reports the victim of the set being trained and records each write.
module btb_plru #(
    parameter int SETS  = 128,
    parameter int IDX_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             touch,
    input  logic [1:0]       touch_way,
    output logic [1:0]       victim
);

    logic [2:0] tree_q [SETS];

    // Reset the trees, then update the touched set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) tree_q[i] <= '0;
        end else if (touch) begin
            tree_q[idx] <= btb_pkg::plru_touch(tree_q[idx], touch_way);
        end
    end

    // Victim for the indexed set.
    always_comb victim = btb_pkg::plru_victim(tree_q[idx]);

endmodule

// File: rtl/btb_redirect.sv
// Compares the prediction fetch acted on with the resolved outcome and
// registers a one-cycle restart request carrying the real next address.
module btb_redirect #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_pred_taken,
    input  logic [ADDR_W-1:0] res_pred_next,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc
);

    logic [ADDR_W-1:0] real_next;
    logic              wrong;

    // Real next address and whether the prediction missed it.
    always_comb begin
        real_next = res_taken ? res_target : res_pc + ADDR_W'(4);
        wrong     = (res_pred_taken != res_taken) || (res_pred_next != real_next);
    end

    // Register the pulse and its address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redirect_valid <= 1'b0;
            redirect_pc    <= '0;
        end else begin
            redirect_valid <= res_valid && wrong;
            redirect_pc    <= real_next;
        end
    end

endmodule

// File: rtl/btb_two_level.sv
// Set-associative branch target buffer with per-entry outcome history
// selecting per-entry saturating counters. Lookup is combinational and
// sees the state a same-cycle training write leaves behind. Assumes
// 4-byte aligned fetch addresses and four ways.
module btb_two_level #(
    parameter int ADDR_W = 32,
    parameter int SETS   = 128,
    parameter int HIST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] fetch_pc,
    output logic              pred_hit,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_next,
    input  logic              res_valid,
    input  logic [ADDR_W-1:0] res_pc,
    input  logic              res_taken,
    input  logic [ADDR_W-1:0] res_target,
    input  logic              res_pred_taken,
    input  logic [ADDR_W-1:0] res_pred_next,
    output logic              redirect_valid,
    output logic [ADDR_W-1:0] redirect_pc
);

    localparam int WAYS    = btb_pkg::WAYS;
    localparam int WAY_W   = $clog2(WAYS);
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - IDX_W - 2;
    localparam int NCTR    = 1 << HIST_W;
    localparam int CTR_VEC = 2 * NCTR;

    logic [IDX_W-1:0] lk_idx, res_idx;
    logic [TAG_W-1:0] lk_tag, res_tag;

    logic [WAYS-1:0]    lk_v, up_v, we, we_tgt;
    logic [TAG_W-1:0]   lk_t [WAYS];
    logic [TAG_W-1:0]   up_t [WAYS];
    logic [HIST_W-1:0]  lk_h [WAYS];
    logic [HIST_W-1:0]  up_h [WAYS];
    logic [ADDR_W-1:0]  lk_tg [WAYS];
    logic [CTR_VEC-1:0] lk_c [WAYS];
    logic [CTR_VEC-1:0] up_c [WAYS];

    logic [TAG_W-1:0]   wr_tag;
    logic [HIST_W-1:0]  wr_hist;
    logic [CTR_VEC-1:0] wr_ctrs;

    logic               up_hit, inv_found, do_write;
    logic [WAY_W-1:0]   hit_way, inv_way, sel_way, plru_way;
    logic [HIST_W-1:0]  base_hist;
    logic [CTR_VEC-1:0] base_ctrs;

    logic               fwd;
    logic [WAYS-1:0]    vv, lk_match;
    logic [TAG_W-1:0]   vt [WAYS];
    logic [HIST_W-1:0]  vh [WAYS];
    logic [ADDR_W-1:0]  vtg [WAYS];
    logic [CTR_VEC-1:0] vc [WAYS];
    logic [HIST_W-1:0]  s_h;
    logic [CTR_VEC-1:0] s_c;
    logic [ADDR_W-1:0]  s_tg;
    logic [1:0]         s_ctr;

    // Split both addresses into set index and tag.
    always_comb begin
        lk_idx  = fetch_pc[IDX_W+1:2];
        lk_tag  = fetch_pc[ADDR_W-1:IDX_W+2];
        res_idx = res_pc[IDX_W+1:2];
        res_tag = res_pc[ADDR_W-1:IDX_W+2];
    end

    generate
        for (genvar w = 0; w < WAYS; w++) begin : g_way
            btb_way_store #(
                .SETS(SETS), .IDX_W(IDX_W), .TAG_W(TAG_W), .HIST_W(HIST_W),
                .ADDR_W(ADDR_W), .CTR_VEC(CTR_VEC)
            ) u_store (
                .clk(clk), .rst_n(rst_n),
                .lk_idx(lk_idx), .lk_valid(lk_v[w]), .lk_tag(lk_t[w]),
                .lk_hist(lk_h[w]), .lk_target(lk_tg[w]), .lk_ctrs(lk_c[w]),
                .up_idx(res_idx), .up_valid(up_v[w]), .up_tag(up_t[w]),
                .up_hist(up_h[w]), .up_ctrs(up_c[w]),
                .we(we[w]), .we_tgt(we_tgt[w]), .wr_tag(wr_tag),
                .wr_hist(wr_hist), .wr_target(res_target), .wr_ctrs(wr_ctrs)
            );
        end
    endgenerate

    btb_plru #(.SETS(SETS), .IDX_W(IDX_W)) u_plru (
        .clk(clk), .rst_n(rst_n), .idx(res_idx),
        .touch(do_write), .touch_way(sel_way), .victim(plru_way)
    );

    // Training side: find the way, build the trained entry, pick write enables.
    always_comb begin
        up_hit    = 1'b0;
        hit_way   = '0;
        inv_found = 1'b0;
        inv_way   = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (up_v[w] && up_t[w] == res_tag) begin
                up_hit  = 1'b1;
                hit_way = WAY_W'(w);
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!up_v[w]) begin
                inv_found = 1'b1;
                inv_way   = WAY_W'(w);
            end
        end
        sel_way   = up_hit ? hit_way : (inv_found ? inv_way : plru_way);
        base_hist = up_hit ? up_h[hit_way] : '0;
        base_ctrs = up_hit ? up_c[hit_way] : {NCTR{2'b10}};
        wr_ctrs   = base_ctrs;
        for (int k = 0; k < NCTR; k++) begin
            if (HIST_W'(k) == base_hist)
                wr_ctrs[2*k +: 2] = btb_pkg::ctr_step(base_ctrs[2*k +: 2], res_taken);
        end
        wr_hist  = {base_hist[HIST_W-2:0], res_taken};
        wr_tag   = res_tag;
        do_write = res_valid && (up_hit || res_taken);
        we       = do_write ? (WAYS'(1) << sel_way) : '0;
        we_tgt   = res_taken ? we : '0;
    end

    // Lookup view of each way, with a same-set training write forwarded.
    always_comb begin
        fwd = (res_idx == lk_idx);
        for (int w = 0; w < WAYS; w++) begin
            vv[w]       = (fwd && we[w]) ? 1'b1    : lk_v[w];
            vt[w]       = (fwd && we[w]) ? wr_tag  : lk_t[w];
            vh[w]       = (fwd && we[w]) ? wr_hist : lk_h[w];
            vc[w]       = (fwd && we[w]) ? wr_ctrs : lk_c[w];
            vtg[w]      = (fwd && we_tgt[w]) ? res_target : lk_tg[w];
            lk_match[w] = vv[w] && (vt[w] == lk_tag);
        end
    end

    // Select the matching way and form the prediction.
    always_comb begin
        s_h  = '0;
        s_c  = '0;
        s_tg = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (lk_match[w]) begin
                s_h  = vh[w];
                s_c  = vc[w];
                s_tg = vtg[w];
            end
        end
        s_ctr      = s_c[{s_h, 1'b0} +: 2];
        pred_hit   = |lk_match;
        pred_taken = pred_hit && s_ctr[1];
        pred_next  = pred_taken ? s_tg : fetch_pc + ADDR_W'(4);
    end

    btb_redirect #(.ADDR_W(ADDR_W)) u_redirect (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_pc(res_pc),
        .res_taken(res_taken), .res_target(res_target),
        .res_pred_taken(res_pred_taken), .res_pred_next(res_pred_next),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

endmodule

// File: rtl/btb_two_level_chk.sv
// Property checker for the branch target buffer, bound to the top module.
module btb_two_level_chk #(
    parameter int ADDR_W = 32,
    parameter int WAYS   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] fetch_pc,
    input logic              pred_hit,
    input logic              pred_taken,
    input logic [ADDR_W-1:0] pred_next,
    input logic              res_valid,
    input logic [ADDR_W-1:0] res_pc,
    input logic              res_taken,
    input logic [ADDR_W-1:0] res_target,
    input logic              res_pred_taken,
    input logic [ADDR_W-1:0] res_pred_next,
    input logic              redirect_valid,
    input logic [ADDR_W-1:0] redirect_pc,
    input logic [WAYS-1:0]   lk_match
);

    // R2: a miss falls through to the sequential address.
    a_r2_miss_sequential: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_hit |-> (!pred_taken && pred_next == fetch_pc + ADDR_W'(4)));

    // R8: tags are unique inside a set.
    a_r8_single_way: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));

    // R9: a redirect follows a resolution and carries its real next address.
    a_r9_redirect_addr: assert property (@(posedge clk) disable iff (!rst_n)
        redirect_valid |-> ($past(res_valid) &&
            redirect_pc == $past(res_taken ? res_target : res_pc + ADDR_W'(4))));

    // R9: a correct prediction never restarts fetch.
    a_r9_no_false_redirect: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pred_taken == res_taken &&
         res_pred_next == (res_taken ? res_target : res_pc + ADDR_W'(4)))
        |=> !redirect_valid);

    // R3: a taken resolution leaves the branch findable on the next cycle.
    a_r3_taken_allocates: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_taken) |=> (fetch_pc != $past(res_pc) || pred_hit));

endmodule

bind btb_two_level btb_two_level_chk #(.ADDR_W(ADDR_W), .WAYS(WAYS)) u_chk (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
    .pred_taken(pred_taken), .pred_next(pred_next), .res_valid(res_valid),
    .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
    .res_pred_taken(res_pred_taken), .res_pred_next(res_pred_next),
    .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
    .lk_match(lk_match)
);

// File: tb/btb_two_level_tb_top.sv
// Scoreboard bench: the driver pushes expected items tagged with the cycle
// they are due; a monitor pops and compares them at the falling edge.
module btb_two_level_tb_top;

    typedef struct {
        bit          is_look;
        int          due;
        string       req;
        bit          e_hit;
        bit          e_taken;
        logic [31:0] e_next;
        bit          e_rv;
        logic [31:0] e_rpc;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] fetch_pc = '0;
    logic        pred_hit, pred_taken;
    logic [31:0] pred_next;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [31:0] res_target = '0;
    logic        res_pred_taken = 1'b0;
    logic [31:0] res_pred_next = '0;
    logic        redirect_valid;
    logic [31:0] redirect_pc;

    int   cyc = 0;
    int   n_checks = 0;
    int   n_fails = 0;
    exp_t q[$];
    exp_t it;

    localparam logic [31:0] IDLE = 32'h0000_F000;
    localparam logic [31:0] A = 32'h0000_1040;
    localparam logic [31:0] B = 32'h0000_1240;
    localparam logic [31:0] C = 32'h0000_1440;
    localparam logic [31:0] D = 32'h0000_1640;
    localparam logic [31:0] E = 32'h0000_1840;

    always #10 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    btb_two_level dut_i (
        .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .pred_hit(pred_hit),
        .pred_taken(pred_taken), .pred_next(pred_next), .res_valid(res_valid),
        .res_pc(res_pc), .res_taken(res_taken), .res_target(res_target),
        .res_pred_taken(res_pred_taken), .res_pred_next(res_pred_next),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc)
    );

    // Monitor: compare every item due in this cycle.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            it = q.pop_front();
            n_checks++;
            if (it.is_look) begin
                if (pred_hit !== it.e_hit || pred_taken !== it.e_taken || pred_next !== it.e_next) begin
                    n_fails++;
                    $display("FAIL %s lookup: actual hit=%0b taken=%0b next=%h, expected hit=%0b taken=%0b next=%h",
                             it.req, pred_hit, pred_taken, pred_next, it.e_hit, it.e_taken, it.e_next);
                end
            end else begin
                if (redirect_valid !== it.e_rv || (it.e_rv && redirect_pc !== it.e_rpc)) begin
                    n_fails++;
                    $display("FAIL %s redirect: actual valid=%0b pc=%h, expected valid=%0b pc=%h",
                             it.req, redirect_valid, redirect_pc, it.e_rv, it.e_rpc);
                end
            end
        end
    end

    // Driver: one cycle of stimulus plus its expectations.
    task automatic step(input logic [31:0] lpc, input bit chk, input bit eh, input bit et,
                        input logic [31:0] en, input bit rv, input logic [31:0] rpc,
                        input bit rt, input logic [31:0] rtgt, input bit rpt,
                        input logic [31:0] rpn, input string req);
        exp_t        li, ri;
        logic [31:0] real_next;
        @(posedge clk);
        #1;
        fetch_pc       = lpc;
        res_valid      = rv;
        res_pc         = rpc;
        res_taken      = rt;
        res_target     = rtgt;
        res_pred_taken = rpt;
        res_pred_next  = rpn;
        if (chk) begin
            li = '{is_look: 1'b1, due: cyc, req: req, e_hit: eh, e_taken: et,
                   e_next: en, e_rv: 1'b0, e_rpc: '0};
            q.push_back(li);
        end
        real_next = rt ? rtgt : rpc + 32'd4;
        ri = '{is_look: 1'b0, due: cyc + 1, req: (rv ? req : "R9"), e_hit: 1'b0,
               e_taken: 1'b0, e_next: '0,
               e_rv: rv && (rpt != rt || rpn != real_next), e_rpc: real_next};
        q.push_back(ri);
    endtask

    task automatic look(input logic [31:0] pc, input bit eh, input bit et,
                        input logic [31:0] en, input string req);
        step(pc, 1'b1, eh, et, en, 1'b0, '0, 1'b0, '0, 1'b0, '0, req);
    endtask

    task automatic resolve(input logic [31:0] pc, input bit t, input logic [31:0] tgt,
                           input bit pt, input logic [31:0] pn, input string req);
        step(IDLE, 1'b0, 1'b0, 1'b0, '0, 1'b1, pc, t, tgt, pt, pn, req);
    endtask

    task automatic summary;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    endtask

    initial begin
        exp_t r0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state, redirect low in the first cycle and lookup misses.
        @(posedge clk);
        #1;
        r0 = '{is_look: 1'b0, due: cyc, req: "R1", e_hit: 1'b0, e_taken: 1'b0,
               e_next: '0, e_rv: 1'b0, e_rpc: '0};
        q.push_back(r0);
        look(A, 0, 0, A + 4, "R1");
        look(32'h0000_2000, 0, 0, 32'h0000_2004, "R2");
        // R3: not-taken miss allocates nothing.
        resolve(A, 0, 32'h0, 0, A + 4, "R3");
        look(A, 0, 0, A + 4, "R3");
        // R9 and R4: taken miss redirects and allocates a taken-predicting entry.
        resolve(A, 1, 32'h0000_2000, 0, A + 4, "R9");
        look(A, 1, 1, 32'h0000_2000, "R4");
        // R7: taken with a new target replaces the stored target.
        resolve(A, 1, 32'h0000_3000, 1, 32'h0000_2000, "R7");
        look(A, 1, 1, 32'h0000_3000, "R7");
        // R6: history walks through fresh counters while outcomes are not-taken.
        resolve(A, 0, 32'h0, 1, 32'h0000_3000, "R6");
        look(A, 1, 1, 32'h0000_3000, "R6");
        resolve(A, 0, 32'h0, 1, 32'h0000_3000, "R6");
        look(A, 1, 1, 32'h0000_3000, "R6");
        resolve(A, 0, 32'h0, 1, 32'h0000_3000, "R6");
        look(A, 1, 1, 32'h0000_3000, "R6");
        resolve(A, 0, 32'h0, 1, 32'h0000_3000, "R6");
        look(A, 1, 1, 32'h0000_3000, "R6");
        // R5: counter 0 counts down through the threshold and saturates.
        resolve(A, 0, 32'h0, 1, 32'h0000_3000, "R5");
        look(A, 1, 1, 32'h0000_3000, "R5");
        resolve(A, 0, 32'h0, 1, 32'h0000_3000, "R5");
        look(A, 1, 0, A + 4, "R5");
        resolve(A, 0, 32'h0, 0, A + 4, "R9");
        look(A, 1, 0, A + 4, "R5");
        resolve(A, 0, 32'h0, 0, A + 4, "R5");
        look(A, 1, 0, A + 4, "R5");
        resolve(A, 1, 32'h0000_3000, 0, A + 4, "R9");
        look(A, 1, 1, 32'h0000_3000, "R6");
        resolve(A, 1, 32'h0000_3000, 1, 32'h0000_3000, "R9");
        look(A, 1, 0, A + 4, "R6");
        // R9: not-taken with a wrong predicted next address still redirects.
        resolve(32'h0000_8000, 0, 32'h0, 0, 32'h0000_9000, "R9");
        look(32'h0000_8000, 0, 0, 32'h0000_8004, "R3");
        // R8: fill the set, touch A, then a new branch evicts C.
        resolve(B, 1, 32'h0000_4000, 0, B + 4, "R8");
        resolve(C, 1, 32'h0000_5000, 0, C + 4, "R8");
        resolve(D, 1, 32'h0000_6000, 0, D + 4, "R8");
        resolve(A, 1, 32'h0000_3000, 1, 32'h0000_3000, "R8");
        resolve(E, 1, 32'h0000_7000, 0, E + 4, "R8");
        look(C, 0, 0, C + 4, "R8");
        look(A, 1, 1, 32'h0000_3000, "R8");
        look(B, 1, 1, 32'h0000_4000, "R8");
        look(D, 1, 1, 32'h0000_6000, "R8");
        look(E, 1, 1, 32'h0000_7000, "R8");
        // R10: lookup in the same cycle as an allocation sees the new entry.
        step(C, 1'b1, 1, 1, 32'h0000_5500, 1'b1, C, 1, 32'h0000_5500, 0, C + 4, "R10");
        look(B, 0, 0, B + 4, "R8");
        // R10: lookup in the same cycle as a hit update sees new history and target.
        step(A, 1'b1, 1, 1, 32'h0000_3300, 1'b1, A, 1, 32'h0000_3300, 1, 32'h0000_3000, "R10");
        look(A, 1, 1, 32'h0000_3300, "R10");
        look(IDLE, 0, 0, IDLE + 4, "R2");
        step(IDLE, 1'b0, 0, 0, '0, 1'b0, '0, 0, '0, 0, '0, "R9");
        @(posedge clk);
        @(negedge clk);
        @(posedge clk);
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual run still active, expected completion");
        summary();
        $finish;
    end

endmodule